// File: doc/BRIEF.md
# Eight-bit Arithmetic and Logic Unit with Status Flag Byte

This block is the arithmetic core of an accumulator-based processor datapath. It takes the accumulator value, a second operand and a four-bit operation code, and produces an eight-bit result in the same cycle. The second operand has already been selected outside the block, from an immediate, a register or memory. The carry used by add-with-carry and subtract-with-borrow enters on its own input.

The block also builds the next status byte from the result. That byte holds sign, zero, auxiliary carry, parity and carry, and it is loaded into a flag register on a clock edge when a write strobe is high. Increment and decrement work on the second operand, so their result can be written to any register chosen by the datapath. Compare computes a difference only for its flags. A destination-write output tells the datapath whether the result should be stored.

Top module: `alu8_core`

## Requirements
- R1: Add (code 0) gives result = (A + B) mod 256. Add-with-carry (code 1) gives (A + B + cy_i) mod 256. In both, carry (flag bit 0) is set when the unsigned sum exceeds 255. Add ignores cy_i.
- R2: Subtract (code 2) gives (A − B) mod 256. Subtract-with-borrow (code 3) gives (A − B − cy_i) mod 256. Carry acts as borrow and is set when B plus the incoming borrow exceeds A.
- R3: Compare (code 7) produces the same result and next flags as subtract, with dest_wr_o low.
- R4: Auxiliary carry (flag bit 4) has these values:
  - add-type and increment: set on a carry out of the low nibble;
  - subtract-type, compare and decrement: set on a borrow into bit 4, that is, when B's low nibble plus the borrow exceeds A's low nibble;
  - AND (code 4): 1;
  - OR (code 5) and XOR (code 6): 0.
- R5: Sign (bit 7) equals result bit 7. Zero (bit 6) is set when the result is 0. Parity (bit 2) is set when the result has an even count of ones.
- R6: Increment (code 8) and decrement (code 9) act on B, give B+1 or B−1 mod 256, set dest_wr_o, and copy cy_i into the carry flag unchanged.
- R7: AND, OR and XOR give the bitwise result of A and B, clear carry and set dest_wr_o.
- R8: The flag byte is packed as {S, Z, 0, AC, 0, P, 1, CY} from bit 7 to bit 0, so bits 5 and 3 are always 0 and bit 1 is always 1.
- R9: flags_o resets to 8'h02. It loads flags_next_o on a rising clock edge when flag_we_i is high and holds its value otherwise.
- R10: Codes 10 to 15 are unused. For these, result_o equals A, dest_wr_o is low, and flags_next_o equals flags_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_i | input | 8 | Accumulator operand A |
| opnd_i | input | 8 | Second operand B |
| op_i | input | 4 | Operation code |
| cy_i | input | 1 | Current carry, used as carry-in or borrow-in |
| flag_we_i | input | 1 | Flag register write strobe |
| result_o | output | 8 | Combinational result |
| dest_wr_o | output | 1 | Result should be written to its destination |
| flags_next_o | output | 8 | Combinational next flag byte |
| flags_o | output | 8 | Registered flag byte |

## Verification
The assertions assume that op_i, cy_i and flag_we_i are known, non-X values at every sampled edge after reset. They also assume that flag_we_i alone decides whether the register loads. The bench meets these assumptions by driving every input to a defined value before reset is released. It changes inputs only on falling edges, so each rising edge samples stable operands. Unused codes are applied only after the flag register holds a known, non-reset value, so the hold behaviour of R10 can be seen.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW = 8;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBB = 4'd3,
    OP_AND = 4'd4,
    OP_OR  = 4'd5,
    OP_XOR = 4'd6,
    OP_CMP = 4'd7,
    OP_INC = 4'd8,
    OP_DEC = 4'd9
  } alu_op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic k5;
    logic ac;
    logic k3;
    logic p;
    logic k1;
    logic cy;
  } flags_t;

  localparam logic [7:0] FLAGS_RST = 8'h02;

  function automatic logic even_ones(input logic [DW-1:0] v);
    return ~^v;
  endfunction

  function automatic flags_t pack_flags(input logic [DW-1:0] res,
                                        input logic ac, input logic cy);
    flags_t f;
    f.s  = res[DW-1];
    f.z  = (res == '0);
    f.k5 = 1'b0;
    f.ac = ac;
    f.k3 = 1'b0;
    f.p  = even_ones(res);
    f.k1 = 1'b1;
    f.cy = cy;
    return f;
  endfunction
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         half
);
  localparam int H  = W / 2;
  localparam int HU = W - H;

  logic [W-1:0] b_eff;
  logic         c_eff;
  logic [H:0]   lo;
  logic [HU:0]  hi;

  function automatic logic [H:0] lo_add(input logic [H-1:0] x,
                                        input logic [H-1:0] y,
                                        input logic c);
    return {1'b0, x} + {1'b0, y} + {{H{1'b0}}, c};
  endfunction

  function automatic logic [HU:0] hi_add(input logic [HU-1:0] x,
                                         input logic [HU-1:0] y,
                                         input logic c);
    return {1'b0, x} + {1'b0, y} + {{HU{1'b0}}, c};
  endfunction

  always_comb begin
    b_eff = sub ? ~b : b;
    c_eff = sub ? ~cin : cin;
    lo    = lo_add(a[H-1:0], b_eff[H-1:0], c_eff);
    hi    = hi_add(a[W-1:H], b_eff[W-1:H], lo[H]);
    sum   = {hi[HU-1:0], lo[H-1:0]};
    cout  = hi[HU] ^ sub;
    half  = lo[H] ^ sub;
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y
);
  always_comb begin
    case (op)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg #(
  parameter int          W   = 8,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST;
    else if (we) q <= d;
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] acc_i,
  input  logic [7:0] opnd_i,
  input  logic [3:0] op_i,
  input  logic       cy_i,
  input  logic       flag_we_i,
  output logic [7:0] result_o,
  output logic       dest_wr_o,
  output logic [7:0] flags_next_o,
  output logic [7:0] flags_o
);
  alu_op_e        op;
  logic [DW-1:0]  ar_a, ar_b, ar_sum, lg_y;
  logic           ar_cin, ar_sub;
  logic           carry_out, half_carry;
  logic           is_arith, is_logic, is_step, is_known;
  flags_t         fn;

  assign op = alu_op_e'(op_i);

  always_comb begin
    ar_a   = acc_i;
    ar_b   = opnd_i;
    ar_cin = 1'b0;
    ar_sub = 1'b0;
    case (op)
      OP_ADC:         ar_cin = cy_i;
      OP_SUB, OP_CMP: ar_sub = 1'b1;
      OP_SBB: begin ar_sub = 1'b1; ar_cin = cy_i; end
      OP_INC: begin ar_a = opnd_i; ar_b = '0; ar_cin = 1'b1; end
      OP_DEC: begin ar_a = opnd_i; ar_b = '0; ar_cin = 1'b1; ar_sub = 1'b1; end
      default: ;
    endcase
  end

  alu8_arith #(.W(DW)) u_arith (
    .a(ar_a), .b(ar_b), .cin(ar_cin), .sub(ar_sub),
    .sum(ar_sum), .cout(carry_out), .half(half_carry)
  );

  alu8_logic #(.W(DW)) u_logic (
    .a(acc_i), .b(opnd_i), .op(op), .y(lg_y)
  );

  always_comb begin
    is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    is_step  = (op == OP_INC) || (op == OP_DEC);
    is_arith = (op_i <= 4'd3) || (op == OP_CMP) || is_step;
    is_known = is_arith || is_logic;

    if (is_logic)      result_o = lg_y;
    else if (is_arith) result_o = ar_sum;
    else               result_o = acc_i;

    dest_wr_o = is_known && (op != OP_CMP);

    if (is_logic)     fn = pack_flags(result_o, op == OP_AND, 1'b0);
    else if (is_step) fn = pack_flags(result_o, half_carry, cy_i);
    else              fn = pack_flags(result_o, half_carry, carry_out);

    flags_next_o = is_known ? fn : flags_o;
  end

  alu8_flagreg #(.W(8), .RST(FLAGS_RST)) u_flags (
    .clk(clk), .rst_n(rst_n), .we(flag_we_i),
    .d(flags_next_o), .q(flags_o)
  );
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] acc_i,
  input logic [7:0] opnd_i,
  input logic [3:0] op_i,
  input logic       cy_i,
  input logic       flag_we_i,
  input logic [7:0] result_o,
  input logic       dest_wr_o,
  input logic [7:0] flags_next_o,
  input logic [7:0] flags_o
);
  // R9
  flag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we_i |=> flags_o == $past(flags_next_o));

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we_i |=> $stable(flags_o));

  // R8
  flag_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o[5] == 1'b0) && (flags_o[3] == 1'b0) && flags_o[1]);

  // R3
  cmp_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd7) |-> !dest_wr_o);

  // R6
  step_cy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd8 || op_i == 4'd9) |-> (flags_next_o[0] == cy_i) && dest_wr_o);

  // R7
  logic_cy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i >= 4'd4 && op_i <= 4'd6) |-> !flags_next_o[0]);

  // R5
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i <= 4'd9) |-> flags_next_o[6] == (result_o == 8'h00));

  // R1
  add_cy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd0) |-> flags_next_o[0] == (({1'b0, acc_i} + {1'b0, opnd_i}) > 9'd255));

  // R10
  unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i >= 4'd10) |-> !dest_wr_o && (flags_next_o == flags_o) && (result_o == acc_i));
endmodule

bind alu8_core alu8_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc_i(acc_i), .opnd_i(opnd_i), .op_i(op_i),
  .cy_i(cy_i), .flag_we_i(flag_we_i), .result_o(result_o),
  .dest_wr_o(dest_wr_o), .flags_next_o(flags_next_o), .flags_o(flags_o)
);

// File: tb/tb_alu8_core.sv
`timescale 1ns/1ps
module tb_alu8_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] acc_i = 8'h00, opnd_i = 8'h00;
  logic [3:0] op_i = 4'd0;
  logic       cy_i = 1'b0, flag_we_i = 1'b0;
  logic [7:0] result_o, flags_next_o, flags_o;
  logic       dest_wr_o;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  alu8_core dut (
    .clk(clk), .rst_n(rst_n), .acc_i(acc_i), .opnd_i(opnd_i), .op_i(op_i),
    .cy_i(cy_i), .flag_we_i(flag_we_i), .result_o(result_o),
    .dest_wr_o(dest_wr_o), .flags_next_o(flags_next_o), .flags_o(flags_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h want %0h", tag, act, exp);
    end
  endtask

  function automatic int par_even(input int v);
    int c = 0;
    for (int i = 0; i < 8; i++) c += (v >> i) & 1;
    return (c % 2 == 0) ? 1 : 0;
  endfunction

  // Reference model: returns {dest_wr, result[7:0], flags[7:0]} for codes 0..9
  function automatic int model(input int op, input int a, input int b, input int c);
    int r = 0, ac = 0, cy = 0, wr = 1;
    case (op)
      0, 1: begin
        int ci = (op == 1) ? c : 0;
        r = a + b + ci; cy = (r > 255) ? 1 : 0;
        ac = ((a % 16) + (b % 16) + ci > 15) ? 1 : 0;
      end
      2, 3, 7: begin
        int bi = (op == 3) ? c : 0;
        r = a - b - bi; cy = (b + bi > a) ? 1 : 0;
        ac = ((b % 16) + bi > (a % 16)) ? 1 : 0;
        if (op == 7) wr = 0;
      end
      4: begin r = a & b; ac = 1; end
      5: r = a | b;
      6: r = a ^ b;
      8: begin r = b + 1; ac = ((b % 16) == 15) ? 1 : 0; cy = c; end
      9: begin r = b - 1; ac = ((b % 16) == 0) ? 1 : 0; cy = c; end
      default: ;
    endcase
    r = r & 255;
    return (wr << 16) | (r << 8) | (((r >> 7) & 1) << 7) | ((r == 0 ? 1 : 0) << 6)
           | (ac << 4) | (par_even(r) << 2) | 2 | cy;
  endfunction

  task automatic apply(input int op, input int a, input int b, input int c, input bit we);
    @(negedge clk);
    op_i = op[3:0]; acc_i = a[7:0]; opnd_i = b[7:0]; cy_i = c[0]; flag_we_i = we;
    #1;
  endtask

  task automatic expect_op(input string tag, input int op, input int a, input int b, input int c);
    int m;
    apply(op, a, b, c, 1'b0);
    m = model(op, a, b, c);
    chk({tag, " result"}, result_o, (m >> 8) & 255);
    chk({tag, " flags"}, flags_next_o, m & 255);
    chk({tag, " dest_wr"}, dest_wr_o, (m >> 16) & 1);
  endtask

  task automatic t_reset();
    chk("R9 reset flags", flags_o, 8'h02);
  endtask

  task automatic t_add();
    expect_op("R1 add 0F+01 R4", 0, 8'h0F, 8'h01, 0);
    expect_op("R1 add FF+01 carry R5", 0, 8'hFF, 8'h01, 0);
    expect_op("R1 add ignores cy", 0, 8'h12, 8'h34, 1);
    expect_op("R1 adc cy", 1, 8'h7F, 8'h00, 1);
    expect_op("R1 adc FF+00+1", 1, 8'hFF, 8'h00, 1);
  endtask

  task automatic t_sub();
    expect_op("R2 sub 10-01 R4", 2, 8'h10, 8'h01, 0);
    expect_op("R2 sub 00-01 borrow", 2, 8'h00, 8'h01, 0);
    expect_op("R2 sub equal zero", 2, 8'h5A, 8'h5A, 1);
    expect_op("R2 sbb 05-05-1", 3, 8'h05, 8'h05, 1);
  endtask

  task automatic t_cmp();
    int ms, mc;
    expect_op("R3 cmp less", 7, 8'h20, 8'h31, 0);
    apply(7, 8'h44, 8'h44, 1, 1'b0);
    mc = flags_next_o;
    apply(2, 8'h44, 8'h44, 1, 1'b0);
    ms = flags_next_o;
    chk("R3 cmp flags equal sub", mc, ms);
  endtask

  task automatic t_logic();
    expect_op("R7 and R4", 4, 8'hF0, 8'h3C, 1);
    expect_op("R7 or", 5, 8'h00, 8'h00, 1);
    expect_op("R7 xor", 6, 8'hAA, 8'h55, 1);
  endtask

  task automatic t_step();
    expect_op("R6 inc FF keep cy0", 8, 8'h11, 8'hFF, 0);
    expect_op("R6 inc 0F keep cy1", 8, 8'h11, 8'h0F, 1);
    expect_op("R6 dec 00 keep cy1", 9, 8'h00, 8'h00, 1);
    expect_op("R6 dec 80 keep cy0", 9, 8'hFF, 8'h80, 0);
  endtask

  task automatic t_flagreg();
    int m;
    apply(2, 8'h00, 8'h01, 0, 1'b1);
    m = model(2, 0, 1, 0) & 255;
    @(negedge clk); flag_we_i = 1'b0; #1;
    chk("R9 loaded", flags_o, m);
    chk("R8 fixed bits", flags_o & 8'h2A, 8'h02);
    apply(0, 8'h01, 8'h01, 0, 1'b0);
    @(negedge clk); #1;
    chk("R9 hold without strobe", flags_o, m);
  endtask

  task automatic t_unused();
    int held;
    held = flags_o;
    for (int op = 10; op < 16; op++) begin
      apply(op, 8'h3C, 8'hC3, 1, 1'b1);
      chk("R10 result is acc", result_o, 8'h3C);
      chk("R10 no dest write", dest_wr_o, 0);
      chk("R10 next equals held", flags_next_o, held);
    end
    @(negedge clk); flag_we_i = 1'b0; #1;
    chk("R10 flags unchanged", flags_o, held);
  endtask

  task automatic t_sweep();
    for (int op = 0; op < 10; op++)
      for (int a = 0; a < 256; a += 37)
        for (int b = 0; b < 256; b += 29)
          expect_op("R5 sweep", op, a, b, (a + b + op) & 1);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout want completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    t_add();
    t_sub();
    t_cmp();
    t_logic();
    t_step();
    t_flagreg();
    t_unused();
    t_sweep();
    finish_run();
  end
endmodule